// File: doc/BRIEF.md
# Read-Leveling Window Center Calculator

During read leveling, every byte lane records where its passing window opened and where it closed. Each point is a coarse phase step paired with a fine delay tap. This block turns one lane's pair of window edges into the setting at the middle of the window. It expresses the setting in the same phase/delay encoding the PHY expects. It also keeps a running minimum of the resulting phases across lanes. The leveling sequencer uses that minimum to choose the final ready-delay offset for the chip select.

Each edge is mapped onto a linear tap scale: position = phase × 2^DELAY_W + delay. The midpoint is start + floor((end − start) / 2). It is split back into a phase (upper bits) and a delay (lower bits). In full-rate mode the phase code has a gap: codes 2 and 3 are never used. Phases above 1 are therefore moved down by 2 before the arithmetic, and a result above 1 is moved back up by 2. In half-rate mode the phase code is contiguous. A window whose end lies below its start is flagged as an error instead of giving a wrapped value. One lane is taken per transfer over a valid/ready pair. The sequencer pulses a clear input before the lanes of each chip select.

Top module: `rl_window_center`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and min_phase equals 10.
- R2: With half_rate = 1, the linear positions are start = sp·32 + sd and end = ep·32 + ed (default DELAY_W = 5). The center is start + floor((end − start)/2). out_phase is center / 32 and out_delay is center mod 32.
- R3: With half_rate = 0, an input phase greater than 1 has 2 subtracted before linearizing. An output phase greater than 1 has 2 added, so the result never carries phase 2 or 3.
- R4: If the end position is below the start position, out_error is 1, out_phase and out_delay are 0, and min_phase is left unchanged.
- R5: Each accepted lane without error sets min_phase to the smaller of its previous value and that lane's out_phase, visible in the same cycle as the result.
- R6: min_clr = 1 resets the tracker to 10. When a lane is accepted in the same cycle, min_phase becomes min(10, that lane's phase), or 10 if that lane is an error.
- R7: in_ready is 1 exactly when the output slot is empty or out_ready is 1. While out_valid = 1 and out_ready = 0, the outputs hold steady.
- R8: A lane accepted at a clock edge is presented (out_valid = 1) from that edge on. out_valid falls after a cycle with out_ready = 1 and no new acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_rate | input | 1 | 1: contiguous phase code; 0: full-rate code with gap at 2 and 3 |
| min_clr | input | 1 | Restart the minimum-phase tracker at 10 |
| in_valid | input | 1 | Lane window offered |
| in_ready | output | 1 | Lane window taken this cycle when in_valid is 1 |
| start_phase | input | PHASE_W | Phase at window start |
| start_delay | input | DELAY_W | Delay tap at window start |
| end_phase | input | PHASE_W | Phase at window end |
| end_delay | input | DELAY_W | Delay tap at window end |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed this cycle when out_valid is 1 |
| out_phase | output | PHASE_W | Center phase in hardware encoding |
| out_delay | output | DELAY_W | Center delay tap |
| out_error | output | 1 | Window end lies below window start |
| min_phase | output | MIN_W | Smallest center phase since the last clear |

## Verification
The minimum tracker's restart and a lane's update can land on the same clock edge. In that case the restart must act first, and the arriving phase is then compared against 10. The bench raises min_clr while a lane is handed over, once with a valid window of phase 4 and once with an inverted window. It expects min_phase to read 4 and then 10, starting from a tracker that already holds 0. The output handshake and a new acceptance also share an edge under back-pressure. That case is judged by the new lane's result replacing the held one.

// File: rtl/rl_center_pkg.sv
package rl_center_pkg;
  // Full-rate phase code skips the codes just above GAP_BASE.
  localparam int GAP_BASE = 1;
  localparam int GAP_SIZE = 2;
  localparam int MIN_INIT_DEF = 10;
endpackage

// File: rtl/rl_lin_pos.sv
module rl_lin_pos
  import rl_center_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int DELAY_W = 5,
  localparam int LIN_W = PHASE_W + DELAY_W
) (
  input  logic               half_rate,
  input  logic [PHASE_W-1:0] phase,
  input  logic [DELAY_W-1:0] delay,
  output logic [LIN_W-1:0]   pos
);
  localparam logic [PHASE_W-1:0] GAP_B = PHASE_W'(GAP_BASE);
  localparam logic [PHASE_W-1:0] GAP_S = PHASE_W'(GAP_SIZE);

  logic [PHASE_W-1:0] cphase;

  always_comb begin
    cphase = phase;
    if (!half_rate && (phase > GAP_B)) cphase = phase - GAP_S;
  end

  // max_delay is a power of two: the multiply is a concatenation
  assign pos = {cphase, delay};
endmodule

// File: rtl/rl_mid_split.sv
module rl_mid_split
  import rl_center_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int DELAY_W = 5,
  localparam int LIN_W = PHASE_W + DELAY_W
) (
  input  logic               half_rate,
  input  logic [LIN_W-1:0]   start_pos,
  input  logic [LIN_W-1:0]   end_pos,
  output logic               bad,
  output logic [PHASE_W-1:0] phase,
  output logic [DELAY_W-1:0] delay
);
  localparam logic [PHASE_W-1:0] GAP_B = PHASE_W'(GAP_BASE);
  localparam logic [PHASE_W-1:0] GAP_S = PHASE_W'(GAP_SIZE);

  logic [LIN_W-1:0]   span;
  logic [LIN_W-1:0]   mid;
  logic [PHASE_W-1:0] cph;

  assign bad  = end_pos < start_pos;
  assign span = end_pos - start_pos;
  assign mid  = start_pos + (span >> 1);
  assign cph  = mid[LIN_W-1:DELAY_W];

  always_comb begin
    phase = cph;
    delay = mid[DELAY_W-1:0];
    if (!half_rate && (cph > GAP_B)) phase = cph + GAP_S;
    if (bad) begin
      phase = '0;
      delay = '0;
    end
  end
endmodule

// File: rtl/rl_min_track.sv
module rl_min_track #(
  parameter int PHASE_W = 3,
  parameter int MIN_W = 4,
  parameter int MIN_INIT = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               upd,
  input  logic [PHASE_W-1:0] phase,
  output logic [MIN_W-1:0]   min_q
);
  localparam logic [MIN_W-1:0] INIT_V = MIN_W'(MIN_INIT);

  logic [MIN_W-1:0] base;
  logic [MIN_W-1:0] cand;
  logic [MIN_W-1:0] min_d;
  logic             min_en;

  assign cand = MIN_W'(phase);

  always_comb begin
    base   = clr ? INIT_V : min_q;
    min_d  = (upd && (cand < base)) ? cand : base;
    min_en = clr | upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      min_q <= INIT_V;
    else if (min_en) min_q <= min_d;
  end
endmodule

// File: rtl/rl_window_center.sv
module rl_window_center
  import rl_center_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int DELAY_W = 5,
  parameter int MIN_INIT = MIN_INIT_DEF,
  localparam int LIN_W = PHASE_W + DELAY_W,
  localparam int INIT_BITS = $clog2(MIN_INIT + 1),
  localparam int MIN_W = (INIT_BITS > PHASE_W) ? INIT_BITS : PHASE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_rate,
  input  logic               min_clr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [PHASE_W-1:0] start_phase,
  input  logic [DELAY_W-1:0] start_delay,
  input  logic [PHASE_W-1:0] end_phase,
  input  logic [DELAY_W-1:0] end_delay,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PHASE_W-1:0] out_phase,
  output logic [DELAY_W-1:0] out_delay,
  output logic               out_error,
  output logic [MIN_W-1:0]   min_phase
);
  logic [1:0][PHASE_W-1:0] edge_ph;
  logic [1:0][DELAY_W-1:0] edge_dl;
  logic [1:0][LIN_W-1:0]   edge_pos;

  assign edge_ph = {end_phase, start_phase};
  assign edge_dl = {end_delay, start_delay};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    rl_lin_pos #(.PHASE_W(PHASE_W), .DELAY_W(DELAY_W)) u_lin (
      .half_rate (half_rate),
      .phase     (edge_ph[g]),
      .delay     (edge_dl[g]),
      .pos       (edge_pos[g])
    );
  end

  logic               c_bad;
  logic [PHASE_W-1:0] c_phase;
  logic [DELAY_W-1:0] c_delay;

  rl_mid_split #(.PHASE_W(PHASE_W), .DELAY_W(DELAY_W)) u_mid (
    .half_rate (half_rate),
    .start_pos (edge_pos[0]),
    .end_pos   (edge_pos[1]),
    .bad       (c_bad),
    .phase     (c_phase),
    .delay     (c_delay)
  );

  logic load;
  logic vld_q, vld_d;
  logic err_q;
  logic [PHASE_W-1:0] ph_q;
  logic [DELAY_W-1:0] dl_q;

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ph_q  <= '0;
      dl_q  <= '0;
    end else if (load) begin
      err_q <= c_bad;
      ph_q  <= c_phase;
      dl_q  <= c_delay;
    end
  end

  rl_min_track #(.PHASE_W(PHASE_W), .MIN_W(MIN_W), .MIN_INIT(MIN_INIT)) u_min (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (min_clr),
    .upd   (load && !c_bad),
    .phase (c_phase),
    .min_q (min_phase)
  );

  assign out_valid = vld_q;
  assign out_error = err_q;
  assign out_phase = ph_q;
  assign out_delay = dl_q;
endmodule

// File: rtl/rl_window_center_chk.sv
module rl_window_center_chk
  import rl_center_pkg::*;
#(
  parameter int PHASE_W = 3,
  parameter int DELAY_W = 5,
  parameter int MIN_W = 4,
  parameter int MIN_INIT = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               half_rate,
  input logic               min_clr,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [PHASE_W-1:0] out_phase,
  input logic [DELAY_W-1:0] out_delay,
  input logic               out_error,
  input logic [MIN_W-1:0]   min_phase
);
  localparam logic [PHASE_W-1:0] GAP_LO = PHASE_W'(GAP_BASE);
  localparam logic [PHASE_W-1:0] GAP_HI = PHASE_W'(GAP_BASE + GAP_SIZE);
  localparam logic [MIN_W-1:0]   INIT_V = MIN_W'(MIN_INIT);

  logic took;
  logic cap_half;
  assign took = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cap_half <= 1'b1;
    else if (took) cap_half <= half_rate;
  end

  p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_error && !cap_half) |-> (out_phase <= GAP_LO || out_phase > GAP_HI));

  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_error) |-> (out_phase == '0 && out_delay == '0));

  p_min_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !min_clr |=> min_phase <= $past(min_phase));

  p_clr_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    min_clr |=> min_phase <= INIT_V);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_phase) && $stable(out_delay)
                                   && $stable(out_error)));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    took |=> out_valid);

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !took) |=> !out_valid);
endmodule

bind rl_window_center rl_window_center_chk #(
  .PHASE_W (PHASE_W),
  .DELAY_W (DELAY_W),
  .MIN_W   (MIN_W),
  .MIN_INIT(MIN_INIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .half_rate (half_rate),
  .min_clr   (min_clr),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_phase (out_phase),
  .out_delay (out_delay),
  .out_error (out_error),
  .min_phase (min_phase)
);

// File: tb/test_rl_window_center.sv
module test_rl_window_center;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {half, sp[3], sd[5], ep[3], ed[5], err, xp[3], xd[5]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 3'd4, 5'd0,  3'd5, 5'd31, 1'b0, 3'd4, 5'd31},
    {1'b0, 3'd1, 5'd20, 3'd5, 5'd0,  1'b0, 3'd4, 5'd10},
    {1'b1, 3'd3, 5'd0,  3'd2, 5'd31, 1'b1, 3'd0, 5'd0},
    {1'b0, 3'd0, 5'd10, 3'd4, 5'd6,  1'b0, 3'd1, 5'd8},
    {1'b0, 3'd5, 5'd3,  3'd4, 5'd9,  1'b1, 3'd0, 5'd0},
    {1'b1, 3'd6, 5'd1,  3'd7, 5'd31, 1'b0, 3'd7, 5'd0},
    {1'b1, 3'd1, 5'd0,  3'd1, 5'd0,  1'b0, 3'd1, 5'd0},
    {1'b1, 3'd2, 5'd30, 3'd3, 5'd5,  1'b0, 3'd3, 5'd1},
    {1'b1, 3'd0, 5'd4,  3'd1, 5'd10, 1'b0, 3'd0, 5'd23}
  };

  logic clk, rst_n;
  logic half_rate, min_clr, in_valid, in_ready, out_valid, out_ready, out_error;
  logic [2:0] start_phase, end_phase, out_phase;
  logic [4:0] start_delay, end_delay, out_delay;
  logic [3:0] min_phase;

  int n_chk = 0;
  int n_fail = 0;
  int mdl_min;
  bit finished = 0;

  rl_window_center i_rl_window_center (
    .clk(clk), .rst_n(rst_n), .half_rate(half_rate), .min_clr(min_clr),
    .in_valid(in_valid), .in_ready(in_ready),
    .start_phase(start_phase), .start_delay(start_delay),
    .end_phase(end_phase), .end_delay(end_delay),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_phase(out_phase), .out_delay(out_delay), .out_error(out_error),
    .min_phase(min_phase)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_vec(input logic [25:0] v);
    half_rate   = v[25];
    start_phase = v[24:22];
    start_delay = v[21:17];
    end_phase   = v[16:14];
    end_delay   = v[13:9];
  endtask

  task automatic check_out(input logic [25:0] v, input string tag);
    check(out_valid == 1'b1, {tag, " out_valid"}, int'(out_valid), 1);
    check(out_error == v[8], {tag, " out_error"}, int'(out_error), int'(v[8]));
    check(out_phase == v[7:5], {tag, " out_phase"}, int'(out_phase), int'(v[7:5]));
    check(out_delay == v[4:0], {tag, " out_delay"}, int'(out_delay), int'(v[4:0]));
  endtask

  task automatic model_min(input logic [25:0] v, input bit clr);
    if (clr) mdl_min = 10;
    if (!v[8] && int'(v[7:5]) < mdl_min) mdl_min = int'(v[7:5]);
  endtask

  // one lane through with out_ready high; optional clear in the same cycle
  task automatic send(input logic [25:0] v, input bit clr, input string tag);
    @(negedge clk);
    load_vec(v);
    in_valid = 1'b1;
    min_clr  = clr;
    @(negedge clk);
    in_valid = 1'b0;
    min_clr  = 1'b0;
    model_min(v, clr);
    check_out(v, tag);
    check(int'(min_phase) == mdl_min, {tag, " min_phase R5"}, int'(min_phase), mdl_min);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; half_rate = 1'b1; min_clr = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    start_phase = '0; start_delay = '0; end_phase = '0; end_delay = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(min_phase == 4'd10, "R1 min_phase", int'(min_phase), 10);
    rst_n = 1'b1;
    mdl_min = 10;

    // R2/R3/R4/R5: table walk
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i], 1'b0, VEC[i][25] ? (VEC[i][8] ? "R4 half" : "R2 half")
                                    : (VEC[i][8] ? "R4 full" : "R3 full"));
      @(negedge clk);
      check(out_valid == 1'b0, "R8 drained", int'(out_valid), 0);
    end

    // R6: clear alone
    @(negedge clk);
    min_clr = 1'b1;
    @(negedge clk);
    min_clr = 1'b0;
    mdl_min = 10;
    check(min_phase == 4'd10, "R6 clear alone", int'(min_phase), 10);

    // R6: drop tracker low, then clear together with a lane of phase 4
    send(VEC[8], 1'b0, "R5 lower");
    send(VEC[0], 1'b1, "R6 clr+lane");
    check(min_phase == 4'd4, "R6 clr+lane min", int'(min_phase), 4);
    // R6: clear together with an error lane
    send(VEC[2], 1'b1, "R6 clr+err");
    check(min_phase == 4'd10, "R6 clr+err min", int'(min_phase), 10);

    // R7: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    load_vec(VEC[7]);
    in_valid = 1'b1;
    @(negedge clk);
    check_out(VEC[7], "R7 first");
    check(in_ready == 1'b0, "R7 in_ready low", int'(in_ready), 0);
    load_vec(VEC[6]);
    @(negedge clk);
    check_out(VEC[7], "R7 held");
    check(in_ready == 1'b0, "R7 still blocked", int'(in_ready), 0);
    check(min_phase == 4'd3, "R5 min after held lane", int'(min_phase), 3);
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R7 in_ready via out_ready", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    check_out(VEC[6], "R7 replaced");
    check(min_phase == 4'd1, "R5 min after swap", int'(min_phase), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 final drain", int'(out_valid), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule